// File: doc/BRIEF.md
# Ring-Oscillator Phase Readout

This block is the digital back end of an oscillator-based converter. A free-running ring oscillator supplies M phase taps. The taps arrive as asynchronous single-bit levels, and the block samples every tap on each converter clock. For each tap it compares the newest sample with the one before and raises a change flag when the level differs, whether the tap rose or fell. Each tap therefore acts as a one-bit counter that counts both edges.

The flags are registered as a vector. Because the set of flags that moved rotates around the ring from sample to sample, the vector can drive a unit-element DAC directly. In the same cycle the block also registers the number of set flags as a binary code. That code is a first-order noise-shaped measure of the oscillator phase advance during one sample period. A valid output marks the cycles in which both sample stages hold real data after reset.

Top module: `phase_readout`

## Requirements
- R1: Every clock samples all M taps. After each edge, bit i of `flags` is 1 exactly when tap i differed between the two most recent samples that precede that edge's sample. This holds for both rising and falling transitions.
- R2: `code` is $clog2(M+1) bits wide and always equals the number of ones in `flags`, so it never exceeds M.
- R3: A tap level that is present before edge n and differs from the level present before edge n-1 shows up in `flags` and `code` right after edge n+1.
- R4: `rst` is synchronous and active high. After any edge taken with `rst` high, `valid`, `flags` and `code` are all zero.
- R5: After reset is released, `valid` is 0 following the first and second edges with `rst` low. It is 1 from the third such edge on, until reset. While `valid` is 0, `flags` and `code` are zero.
- R6: When every tap holds a constant level (the oscillator is stopped), `flags` and `code` stay zero.
- R7: Model the ring as 2M phase steps per period, with tap i high while (phase - i) mod 2M < M. If the phase advances by k steps between samples, with 0 <= k <= M (oscillator at or below half the sample rate), then `code` equals k. The set flags are then exactly the taps whose transition points were crossed, which is a rotating run of adjacent taps.
- R8: Summed over many cycles, `code` stays within M of 2M times the number of oscillator periods elapsed.
- R9: With the default M of 64, `code` is 7 bits wide. It reads 32 with the oscillator at a quarter of the sample rate and 64 at half the sample rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter sample clock |
| rst | input | 1 | Synchronous active-high reset |
| taps | input | M | Asynchronous oscillator phase taps |
| flags | output | M | Registered per-tap change flags |
| code | output | $clog2(M+1) | Registered count of set flags |
| valid | output | 1 | Outputs carry real samples |

## Verification
The bench builds the readout twice. The first instance uses M = 16, which is small enough to sweep every per-sample phase advance from 0 to M, and also an irregular advance sequence that starts from many different ring positions. For each of these the exact flag vector is predicted from the phase model. The second instance uses the default M = 64 and is stepped in multiples of four up to the half-rate boundary. This confirms the 7-bit code at mid-scale and at full scale. A separate long run from reset compares the accumulated code with the number of elapsed oscillator periods.

// File: rtl/phase_readout.sv
module phase_readout #(
  parameter int M = 64,
  localparam int W = $clog2(M + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] taps,
  output logic [M-1:0] flags,
  output logic [W-1:0] code,
  output logic         valid
);

  logic [M-1:0] smp, prev;
  logic [2:0]   warm;
  logic [M-1:0] chg;
  logic [W-1:0] cnt;

  assign chg = warm[1] ? (smp ^ prev) : '0;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < M; i++)
      cnt = cnt + W'(chg[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp   <= '0;
      prev  <= '0;
      warm  <= '0;
      flags <= '0;
      code  <= '0;
    end else begin
      smp   <= taps;
      prev  <= smp;
      warm  <= {warm[1:0], 1'b1};
      flags <= chg;
      code  <= cnt;
    end
  end

  assign valid = warm[2];

endmodule

module phase_readout_chk #(
  parameter int M = 64,
  localparam int W = $clog2(M + 1)
) (
  input logic         clk,
  input logic         rst,
  input logic [M-1:0] flags,
  input logic [W-1:0] code,
  input logic         valid
);

  a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
    code <= W'(M));

  a_r2_code_popcount: assert property (@(posedge clk) disable iff (rst)
    code == W'($countones(flags)));

  a_r5_valid_hold: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);

  a_r5_quiet_until_valid: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (flags == '0 && code == '0));

  a_r4_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid && flags == '0));

endmodule

bind phase_readout phase_readout_chk #(.M(M)) u_chk (
  .clk(clk), .rst(rst), .flags(flags), .code(code), .valid(valid)
);

// File: tb/phase_readout_test.sv
module phase_readout_test;
  localparam int M   = 16;
  localparam int W   = $clog2(M + 1);
  localparam int TW  = 2 * M;
  localparam int MB  = 64;
  localparam int WB  = $clog2(MB + 1);
  localparam int TWB = 2 * MB;

  logic clk = 0;
  logic rst = 1;
  logic [M-1:0]  taps = '0;
  logic [M-1:0]  flags;
  logic [W-1:0]  code;
  logic          valid;
  logic [MB-1:0] taps_b = '0;
  logic [MB-1:0] flags_b;
  logic [WB-1:0] code_b;
  logic          valid_b;

  always #5 clk = ~clk;

  phase_readout #(.M(M)) uut (
    .clk(clk), .rst(rst), .taps(taps), .flags(flags), .code(code), .valid(valid));
  phase_readout uut_full (
    .clk(clk), .rst(rst), .taps(taps_b), .flags(flags_b), .code(code_b), .valid(valid_b));

  int errors = 0, checks = 0;
  int ph = 0, ph_b = 0, edges = 0, settle = 0, inc_b = 0;
  logic [M-1:0] cur, h1, h2, h3;
  int ci, i1, i2, i3;
  longint adv = 0, sum_code = 0;
  bit track = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [M-1:0] ring(input int p);
    logic [M-1:0] t;
    for (int i = 0; i < M; i++) t[i] = ((p + TW - i) % TW) < M;
    return t;
  endfunction

  function automatic logic [MB-1:0] ring_b(input int p);
    logic [MB-1:0] t;
    for (int i = 0; i < MB; i++) t[i] = ((p + TWB - i) % TWB) < MB;
    return t;
  endfunction

  task automatic step(input int inc, input int incb);
    @(negedge clk);
    h3 = h2; h2 = h1; h1 = cur;
    i3 = i2; i2 = i1; i1 = ci;
    edges++;
    settle++;
    chk(valid == (edges >= 3), "R5 valid", valid, edges >= 3);
    if (edges >= 3) begin
      chk(flags == (h2 ^ h3), "R1 flags", flags, h2 ^ h3);
      chk(code == W'(i2), "R7 code", code, i2);
      if (track) sum_code += code;
    end else begin
      chk(flags == '0 && code == '0, "R5 quiet", {code, flags}, 0);
    end
    if (valid_b && settle >= 3)
      chk(code_b == WB'(inc_b), "R9 full code", code_b, inc_b);
    ph = (ph + inc) % TW;
    cur = ring(ph);
    ci = inc;
    taps = cur;
    adv += inc;
    if (incb != inc_b) settle = 0;
    inc_b = incb;
    ph_b = (ph_b + incb) % TWB;
    taps_b = ring_b(ph_b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(valid == 0 && flags == '0 && code == '0, "R4 reset", {valid, code, flags}, 0);
    chk(valid_b == 0 && code_b == '0, "R4 reset full", {valid_b, code_b}, 0);
    @(negedge clk);
    rst = 0;
    edges = 0;
    cur = taps; ci = 0; h1 = taps; h2 = taps; h3 = taps; i1 = 0; i2 = 0; i3 = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid == 0 && flags == '0 && code == '0, "R4 initial reset", {valid, code, flags}, 0);
    taps = ring(0); taps_b = ring_b(0);
    do_reset();
    // R6 stopped oscillator
    repeat (12) step(0, 0);
    // R7 / R9 sweep of every advance up to the half-rate boundary
    for (int k = 0; k <= M; k++)
      repeat (3 * M) step(k, 4 * k);
    // R3 single advance, isolated
    step(0, 0); step(0, 0); step(3, 0); step(0, 0);
    @(negedge clk);
    chk(code == W'(3), "R3 latency", code, 3);
    // mid-run reset
    do_reset();
    // R1 irregular advances from many ring positions
    for (int c = 0; c < 400; c++) step((c * 7 + c / 5) % (M + 1), 32);
    // R8 accumulation from reset
    do_reset();
    adv = 0; sum_code = 0; track = 1;
    for (int c = 0; c < 2000; c++) step((c * 5 + 3) % (M + 1), 64);
    repeat (3) step(0, 0);
    track = 0;
    begin
      longint per = (adv + M) / TW;
      longint dif = sum_code - per * TW;
      chk(dif <= M && dif >= -M, "R8 accumulated", sum_code, per * TW);
      chk(sum_code == adv, "R8 total advance", sum_code, adv);
    end
    chk($bits(code_b) == 7, "R9 width", $bits(code_b), 7);
    chk($bits(code) == W, "R2 width", $bits(code), W);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule